// File: doc/BRIEF.md
# Time-Interleaved SAR Conversion Sequencer

This block sequences sixteen successive-approximation converter slices that share one input clock and run side by side. A single phase counter drives every slice. Each slice reads the counter with its own fixed offset, so the slices follow the same sixteen-cycle program one clock apart. Because of that offset, exactly one slice takes an input sample on every clock.

Each slice runs the same program. It opens with three calibration cycles: it samples the zero reference, makes an offset comparison and then a gain comparison. It then takes its input sample and makes eleven bit decisions, most significant bit first. The last cycle hands the result off. The comparators, the reference ladder, the sampling switches and the calibration integrators sit outside the block. The sequencer sees them only as one comparator bit in per slice, and it drives phase strobes and a trial code out to them.

The finished words from all slices are merged onto one 11-bit result bus, together with a slice index and a valid flag. A word appears on the bus twelve clocks after the clock on which its input was sampled.

Top module: `tisar_sequencer`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset, slice 0 asserts its zero-reference strobe, its trial code is 0, both calibration sign outputs of every slice are 0, and the output valid flag is low.
- R2: Every clock, each slice asserts exactly one of its six strobes. The strobe follows the slice's program position p, counted from 0 to 15: p=0 zero-reference sample, p=1 offset comparison, p=2 gain comparison, p=3 input sample, p=4 to 14 conversion, p=15 transfer.
- R3: In the k-th cycle after reset, counted from 0, slice s is at position p = (k - s) mod 16. Exactly one slice asserts its input-sample strobe on every clock.
- R4: During conversion position p, the slice works on bit b = 14 - p, so bit 10 is decided at p=4 and bit 0 at p=14. The trial code shows the bits already decided, with bit b set to 1 and all lower bits at 0. At the end of that cycle, bit b keeps the comparator input value, where 1 means keep the bit.
- R5: The calibration positions (p=0 to 2) leave the slice's conversion register unchanged. The comparator bit present at p=1 is shown on that slice's offset-sign output from the next cycle onward. The comparator bit present at p=2 is shown on its gain-sign output from the next cycle onward.
- R6: The input-sample position clears the conversion register, so in the first conversion cycle the trial code is exactly 1024.
- R7: While slice s is at p=15, the output word is that slice's 11-bit result and the output index is s. This is 12 clocks after the clock on which slice s sampled.
- R8: The output valid flag is low for cycles 0 to 11 after reset and high on every cycle from cycle 12 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 16 | Comparator decision, one bit per slice (bit s belongs to slice s) |
| zero_smp_o | output | 16 | Zero-reference sample strobe per slice |
| az_cmp_o | output | 16 | Offset comparison strobe per slice |
| gain_cmp_o | output | 16 | Gain comparison strobe per slice |
| smp_en_o | output | 16 | Input-sample enable per slice |
| conv_o | output | 16 | Conversion-active strobe per slice |
| xfer_o | output | 16 | Transfer strobe per slice |
| trial_o | output | 176 | Trial codes; slice s occupies bits [11s+10:11s] |
| az_sign_o | output | 16 | Captured offset comparison bit per slice |
| gain_sign_o | output | 16 | Captured gain comparison bit per slice |
| dout_o | output | 11 | Interleaved result word |
| dout_idx_o | output | 4 | Index of the slice that produced dout_o |
| dout_vld_o | output | 1 | Result valid |

## Verification
Some properties are checked by assertions on every clock:
- each slice asserts exactly one strobe;
- exactly one slice samples, and the sampling slice rotates by one each cycle;
- the phase counter steps by one;
- the trial codes do not change across the calibration positions;
- the valid flag stays high once it has risen, and the output index advances by one and always points at a slice that is in its transfer position.

The bench covers what needs a model of the analog input. An ideal comparator runs against a held random or directed value, including 0, 2047, 1023 and 1024, so that every output word must reproduce that value twelve clocks after its sample. The bench also checks the bit-by-bit trial codes, the capture of the offset and gain signs, the 12-clock fill, and a second reset in the middle of a run.

// File: rtl/tisar_pkg.sv
package tisar_pkg;
  localparam int NBITS    = 11;
  localparam int NSLICE   = NBITS + 5;
  localparam int IDXW     = $clog2(NSLICE);
  localparam int BW       = $clog2(NBITS);
  localparam int PH_ZERO  = 0;
  localparam int PH_AZ    = 1;
  localparam int PH_CAL   = 2;
  localparam int PH_SMP   = 3;
  localparam int PH_CONV0 = 4;
  localparam int PH_XFER  = NSLICE - 1;
  localparam int FILL     = PH_XFER - PH_SMP;
  localparam int FW       = $clog2(FILL + 1);

  typedef struct packed {
    logic zero;
    logic az;
    logic cal;
    logic smp;
    logic conv;
    logic xfer;
  } strobes_t;

  // Program position of a slice: shared count minus slice index, modulo NSLICE.
  function automatic logic [IDXW-1:0] phase_of(input logic [IDXW-1:0] cnt, input int idx);
    int t;
    t = (int'(cnt) + NSLICE - idx) % NSLICE;
    return IDXW'(t);
  endfunction

  // Bit under decision for a conversion position, MSB first.
  function automatic logic [BW-1:0] bit_of(input logic [IDXW-1:0] ph);
    return BW'(PH_CONV0 + NBITS - 1 - int'(ph));
  endfunction

  function automatic strobes_t decode_phase(input logic [IDXW-1:0] ph);
    strobes_t s;
    int p;
    p      = int'(ph);
    s      = '0;
    s.zero = (p == PH_ZERO);
    s.az   = (p == PH_AZ);
    s.cal  = (p == PH_CAL);
    s.smp  = (p == PH_SMP);
    s.conv = (p >= PH_CONV0) && (p < PH_XFER);
    s.xfer = (p == PH_XFER);
    return s;
  endfunction
endpackage

// File: rtl/tisar_phase_gen.sv
module tisar_phase_gen
  import tisar_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [IDXW-1:0] cnt_o,
  output logic            fill_done_o
);
  logic [IDXW-1:0] cnt;
  logic [FW-1:0]   fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fill <= '0;
    end else begin
      cnt <= (int'(cnt) == NSLICE - 1) ? '0 : cnt + 1'b1;
      if (int'(fill) != FILL) fill <= fill + 1'b1;
    end
  end

  assign cnt_o       = cnt;
  assign fill_done_o = (int'(fill) == FILL);
endmodule

// File: rtl/tisar_slice.sv
module tisar_slice
  import tisar_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDXW-1:0]  cnt_i,
  input  logic             cmp_i,
  output strobes_t         stb_o,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] word_o,
  output logic             az_sign_o,
  output logic             gain_sign_o
);
  logic [IDXW-1:0]  ph;
  logic [BW-1:0]    bsel;
  logic [NBITS-1:0] sar;
  logic [NBITS-1:0] trial_mask;

  assign ph    = phase_of(cnt_i, IDX);
  assign stb_o = decode_phase(ph);
  assign bsel  = bit_of(ph);

  always_comb trial_mask = stb_o.conv ? (NBITS'(1) << bsel) : '0;

  assign trial_o = sar | trial_mask;
  assign word_o  = sar;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar         <= '0;
      az_sign_o   <= 1'b0;
      gain_sign_o <= 1'b0;
    end else begin
      if (stb_o.smp)  sar       <= '0;
      if (stb_o.conv) sar[bsel] <= cmp_i;
      if (stb_o.az)   az_sign_o   <= cmp_i;
      if (stb_o.cal)  gain_sign_o <= cmp_i;
    end
  end
endmodule

// File: rtl/tisar_outmux.sv
module tisar_outmux
  import tisar_pkg::*;
(
  input  logic [NSLICE-1:0]            xfer_i,
  input  logic [NSLICE-1:0][NBITS-1:0] words_i,
  input  logic                         fill_done_i,
  output logic [NBITS-1:0]             dout_o,
  output logic [IDXW-1:0]              idx_o,
  output logic                         vld_o
);
  always_comb begin
    dout_o = '0;
    idx_o  = '0;
    for (int s = 0; s < NSLICE; s++) begin
      if (xfer_i[s]) begin
        dout_o = dout_o | words_i[s];
        idx_o  = idx_o | IDXW'(s);
      end
    end
  end

  assign vld_o = fill_done_i & (|xfer_i);
endmodule

// File: rtl/tisar_sequencer.sv
module tisar_sequencer
  import tisar_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLICE-1:0]       cmp_i,
  output logic [NSLICE-1:0]       zero_smp_o,
  output logic [NSLICE-1:0]       az_cmp_o,
  output logic [NSLICE-1:0]       gain_cmp_o,
  output logic [NSLICE-1:0]       smp_en_o,
  output logic [NSLICE-1:0]       conv_o,
  output logic [NSLICE-1:0]       xfer_o,
  output logic [NSLICE*NBITS-1:0] trial_o,
  output logic [NSLICE-1:0]       az_sign_o,
  output logic [NSLICE-1:0]       gain_sign_o,
  output logic [NBITS-1:0]        dout_o,
  output logic [IDXW-1:0]         dout_idx_o,
  output logic                    dout_vld_o
);
  logic [IDXW-1:0]              phase_cnt;
  logic                         fill_done;
  logic [NSLICE-1:0][NBITS-1:0] words;

  tisar_phase_gen u_phase (
    .clk         (clk),
    .rst         (rst),
    .cnt_o       (phase_cnt),
    .fill_done_o (fill_done)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    strobes_t stb;

    tisar_slice #(.IDX(s)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .cnt_i       (phase_cnt),
      .cmp_i       (cmp_i[s]),
      .stb_o       (stb),
      .trial_o     (trial_o[s*NBITS +: NBITS]),
      .word_o      (words[s]),
      .az_sign_o   (az_sign_o[s]),
      .gain_sign_o (gain_sign_o[s])
    );

    assign zero_smp_o[s] = stb.zero;
    assign az_cmp_o[s]   = stb.az;
    assign gain_cmp_o[s] = stb.cal;
    assign smp_en_o[s]   = stb.smp;
    assign conv_o[s]     = stb.conv;
    assign xfer_o[s]     = stb.xfer;
  end

  tisar_outmux u_mux (
    .xfer_i      (xfer_o),
    .words_i     (words),
    .fill_done_i (fill_done),
    .dout_o      (dout_o),
    .idx_o       (dout_idx_o),
    .vld_o       (dout_vld_o)
  );
endmodule

// File: rtl/tisar_sequencer_chk.sv
module tisar_sequencer_chk
  import tisar_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [IDXW-1:0]         phase_cnt,
  input logic [NSLICE-1:0]       zero_smp_o,
  input logic [NSLICE-1:0]       az_cmp_o,
  input logic [NSLICE-1:0]       gain_cmp_o,
  input logic [NSLICE-1:0]       smp_en_o,
  input logic [NSLICE-1:0]       conv_o,
  input logic [NSLICE-1:0]       xfer_o,
  input logic [NSLICE*NBITS-1:0] trial_o,
  input logic [IDXW-1:0]         dout_idx_o,
  input logic                    dout_vld_o
);
  // R3: exactly one sampling slice per clock
  a_r3_one_sampler: assert property (@(posedge clk) disable iff (rst)
    $countones(smp_en_o) == 1);

  // R3: sampling moves to the next slice each clock
  a_r3_sample_rotates: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> smp_en_o == (($past(smp_en_o) << 1) | ($past(smp_en_o) >> (NSLICE - 1))));

  // R3: shared schedule advances by one
  a_r3_counter_steps: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_cnt == IDXW'($past(phase_cnt) + 1'b1));

  // R8: valid low just after reset, then sticky
  a_r8_valid_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout_vld_o);
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    dout_vld_o |=> dout_vld_o);

  // R7: output index advances and points at the transferring slice
  a_r7_idx_advances: assert property (@(posedge clk) disable iff (rst)
    (dout_vld_o && $past(dout_vld_o)) |-> dout_idx_o == IDXW'($past(dout_idx_o) + 1'b1));
  a_r7_idx_is_xfer: assert property (@(posedge clk) disable iff (rst)
    dout_vld_o |-> xfer_o[dout_idx_o]);

  for (genvar s = 0; s < NSLICE; s++) begin : g_chk
    // R2: one strobe per slice
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $countones({zero_smp_o[s], az_cmp_o[s], gain_cmp_o[s],
                  smp_en_o[s], conv_o[s], xfer_o[s]}) == 1);
    // R5: calibration leaves the conversion register alone
    a_r5_cal_holds: assert property (@(posedge clk) disable iff (rst)
      (zero_smp_o[s] || az_cmp_o[s] || gain_cmp_o[s]) |=> $stable(trial_o[s*NBITS +: NBITS]));
  end
endmodule

bind tisar_sequencer tisar_sequencer_chk u_chk (.*);

// File: tb/tisar_sequencer_test.sv
module tisar_sequencer_test;
  import tisar_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NSLICE-1:0]       cmp_i = '0;
  logic [NSLICE-1:0]       zero_smp_o, az_cmp_o, gain_cmp_o, smp_en_o, conv_o, xfer_o;
  logic [NSLICE*NBITS-1:0] trial_o;
  logic [NSLICE-1:0]       az_sign_o, gain_sign_o;
  logic [NBITS-1:0]        dout_o;
  logic [IDXW-1:0]         dout_idx_o;
  logic                    dout_vld_o;

  int errors = 0;
  int checks = 0;
  int vin [NSLICE];
  int prev_ph [NSLICE];
  bit prev_cmp [NSLICE];
  int nsamp = 0;

  always #10 clk = ~clk;

  tisar_sequencer uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pos(input int k, input int s);
    return ((k % 16) + 16 - s) % 16;
  endfunction

  // Expected trial code: decided upper bits of the input plus the bit under test.
  function automatic int exp_trial(input int v, input int b);
    int upper;
    upper = (v >> (b + 1)) << (b + 1);
    return upper + (1 << b);
  endfunction

  function automatic int next_vin();
    int v;
    case (nsamp)
      0: v = 0;
      1: v = 2047;
      2: v = 1024;
      3: v = 1023;
      4: v = 1;
      5: v = 2046;
      default: v = int'($urandom % 2048);
    endcase
    nsamp++;
    return v;
  endfunction

  task automatic check_cycle(input int k);
    logic [NSLICE-1:0] ez, ea, eg, es, ec, ex;
    for (int s = 0; s < NSLICE; s++) begin
      int p;
      p = pos(k, s);
      ez[s] = (p == 0); ea[s] = (p == 1); eg[s] = (p == 2);
      es[s] = (p == 3); ec[s] = (p >= 4 && p <= 14); ex[s] = (p == 15);
    end
    if (k == 0) begin
      chk(zero_smp_o[0] == 1'b1, "R1 slice0 zero strobe", zero_smp_o[0], 1);
      chk(trial_o[NBITS-1:0] == '0, "R1 slice0 trial", trial_o[NBITS-1:0], 0);
      chk(az_sign_o == '0 && gain_sign_o == '0, "R1 signs cleared", {az_sign_o, gain_sign_o}, 0);
    end
    chk({zero_smp_o, az_cmp_o, gain_cmp_o, conv_o, xfer_o} == {ez, ea, eg, ec, ex},
        "R2 strobe program", {zero_smp_o, az_cmp_o, gain_cmp_o, conv_o, xfer_o}, {ez, ea, eg, ec, ex});
    chk(smp_en_o == es, "R3 sample slice", smp_en_o, es);
    chk(dout_vld_o == (k >= 12), "R8 valid fill", dout_vld_o, (k >= 12));
    if (k >= 12) begin
      int si;
      si = (k + 1) % 16;
      chk(dout_idx_o == IDXW'(si), "R7 output index", dout_idx_o, si);
      chk(int'(dout_o) == vin[si], "R7 output word", dout_o, vin[si]);
    end
    for (int s = 0; s < NSLICE; s++) begin
      int p;
      int tr;
      p  = pos(k, s);
      tr = int'(trial_o[s*NBITS +: NBITS]);
      if (p >= 4 && p <= 14 && k >= p - 3) begin
        chk(tr == exp_trial(vin[s], 14 - p), "R4 trial code", tr, exp_trial(vin[s], 14 - p));
        if (p == 4) chk(tr == 1024, "R6 cleared at sample", tr, 1024);
      end
      if (p <= 2 && k >= 16)
        chk(tr == vin[s], "R5 calibration holds result", tr, vin[s]);
      if (k >= 1 && prev_ph[s] == 1)
        chk(az_sign_o[s] == prev_cmp[s], "R5 offset sign", az_sign_o[s], prev_cmp[s]);
      if (k >= 1 && prev_ph[s] == 2)
        chk(gain_sign_o[s] == prev_cmp[s], "R5 gain sign", gain_sign_o[s], prev_cmp[s]);
    end
  endtask

  task automatic drive_cycle(input int k);
    for (int s = 0; s < NSLICE; s++) begin
      int p;
      p = pos(k, s);
      if (p == 3) vin[s] = next_vin();
      if (p >= 4 && p <= 14)
        cmp_i[s] = (int'(trial_o[s*NBITS +: NBITS]) <= vin[s]);
      else
        cmp_i[s] = 1'($urandom);
      prev_ph[s]  = p;
      prev_cmp[s] = cmp_i[s];
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      check_cycle(k);
      drive_cycle(k);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NSLICE; s++) begin
      vin[s] = int'($urandom % 2048);
      prev_ph[s] = -1;
      prev_cmp[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run(300);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < NSLICE; s++) prev_ph[s] = -1;
    rst = 1'b0;
    run(400);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule